// File: doc/BRIEF.md
# Single-Direction Belief-Propagation Polar Node

This block is one node of a belief-propagation decoder for polar codes. It takes four signed log-likelihood messages. Two of them travel towards the source side of the factor graph: `l_in1` and `l_in2`. The other two travel towards the channel side: `r_in1` and `r_in2`. A direction select decides which output pair the node computes in a given cycle. In a leftward sweep it produces only the pair of messages heading left. In a rightward sweep it produces only the pair heading right. Because of this, a single node needs only two compare-select units and two saturating adders.

The compare-select function takes two operands. It returns the smaller of their magnitudes, signed with the product of their signs. Every addition is done one bit wider than a message and then clamped to a symmetric range. The most negative code of the message width is therefore never produced. Results are captured in registers when `in_valid` is high, and `out_valid` accompanies them.

Top module: `bppe_unidir`

## Requirements
- R1: With `dir_right`=0 (left mode), `l_out1` becomes cs(`l_in1`, sat(`l_in2`+`r_in2`)). Here cs(a,b) = sign(a)·sign(b)·min(|a|,|b|), with its magnitude clamped to 15.
- R2: In left mode, `l_out2` becomes sat(cs(`r_in1`,`l_in1`) + `l_in2`).
- R3: With `dir_right`=1 (right mode), `r_out1` becomes cs(`r_in1`, sat(`l_in2`+`r_in2`)).
- R4: In right mode, `r_out2` becomes sat(cs(`r_in1`,`l_in1`) + `r_in2`).
- R5: Every sum and every result saturates to −15..+15, and no output ever equals −16. Messages are 5-bit two's complement.
- R6: If either operand of a compare-select is zero, its result is zero.
- R7: Only the outputs of the selected direction change. The opposite pair keeps its value.
- R8: Results appear at the outputs on the clock edge that samples `in_valid`=1. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high.
- R9: While `in_valid` is low, all four outputs hold and `out_valid` falls.
- R10: A synchronous active-high `rst` clears all outputs and `out_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| dir_right | input | 1 | 0 = left mode, 1 = right mode |
| l_in1 | input | 5 | Left-bound message 1 (signed) |
| l_in2 | input | 5 | Left-bound message 2 (signed) |
| r_in1 | input | 5 | Right-bound message 1 (signed) |
| r_in2 | input | 5 | Right-bound message 2 (signed) |
| out_valid | output | 1 | Registered results updated last cycle |
| l_out1 | output | 5 | Left-bound result 1 (signed) |
| l_out2 | output | 5 | Left-bound result 2 (signed) |
| r_out1 | output | 5 | Right-bound result 1 (signed) |
| r_out2 | output | 5 | Right-bound result 2 (signed) |

## Verification
Each result has one register stage behind it. The updated pair and `out_valid` are therefore due on the first rising edge after the inputs are presented with `in_valid` high. The bench drives inputs at the falling edge. It samples half a period after the next rising edge, where the new values have settled. In that same sample it also checks that the opposite pair still holds the values it recorded earlier. After idle cycles it samples each output again to confirm that nothing moved.

// File: rtl/bppe_pkg.sv
package bppe_pkg;
    localparam int LLR_W   = 5;
    localparam int SUM_W   = LLR_W + 1;
    localparam int MAG_MAX = (1 << (LLR_W - 1)) - 1;

    typedef logic signed [LLR_W-1:0] llr_t;
    typedef logic signed [SUM_W-1:0] wide_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

    typedef struct packed {
        llr_t first;
        llr_t second;
    } pair_t;

    function automatic llr_t clamp_llr(input wide_t v);
        wide_t hi;
        wide_t lo;
        hi = wide_t'(MAG_MAX);
        lo = -hi;
        if (v > hi)      return hi[LLR_W-1:0];
        else if (v < lo) return lo[LLR_W-1:0];
        else             return v[LLR_W-1:0];
    endfunction
endpackage

// File: rtl/bppe_csel.sv
module bppe_csel
    import bppe_pkg::*;
(
    input  llr_t a,
    input  llr_t b,
    output llr_t y
);
    wide_t mag_a, mag_b, mag_min;
    logic  neg;

    always_comb begin
        mag_a   = a[LLR_W-1] ? -wide_t'(a) : wide_t'(a);
        mag_b   = b[LLR_W-1] ? -wide_t'(b) : wide_t'(b);
        mag_min = (mag_a < mag_b) ? mag_a : mag_b;
        if (mag_min > wide_t'(MAG_MAX))
            mag_min = wide_t'(MAG_MAX);
        neg = a[LLR_W-1] ^ b[LLR_W-1];
        if (a == '0 || b == '0)
            y = '0;
        else if (neg)
            y = clamp_llr(-mag_min);
        else
            y = clamp_llr(mag_min);
    end
endmodule

// File: rtl/bppe_satadd.sv
module bppe_satadd
    import bppe_pkg::*;
(
    input  llr_t a,
    input  llr_t b,
    output llr_t y
);
    wide_t sum;

    always_comb begin
        sum = wide_t'(a) + wide_t'(b);
        y   = clamp_llr(sum);
    end
endmodule

// File: rtl/bppe_unidir.sv
module bppe_unidir
    import bppe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic dir_right,
    input  llr_t l_in1,
    input  llr_t l_in2,
    input  llr_t r_in1,
    input  llr_t r_in2,
    output logic out_valid,
    output llr_t l_out1,
    output llr_t l_out2,
    output llr_t r_out1,
    output llr_t r_out2
);
    dir_e  dir;
    llr_t  pre_sum;
    llr_t  cs1_lhs;
    llr_t  post_rhs;
    llr_t  cs2_val;
    pair_t res;

    assign dir      = dir_e'(dir_right);
    assign cs1_lhs  = (dir == DIR_RIGHT) ? r_in1 : l_in1;
    assign post_rhs = (dir == DIR_RIGHT) ? r_in2 : l_in2;

    bppe_satadd u_pre  (.a(l_in2),   .b(r_in2),    .y(pre_sum));
    bppe_csel   u_cs1  (.a(cs1_lhs), .b(pre_sum),  .y(res.first));
    bppe_csel   u_cs2  (.a(r_in1),   .b(l_in1),    .y(cs2_val));
    bppe_satadd u_post (.a(cs2_val), .b(post_rhs), .y(res.second));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            l_out1    <= '0;
            l_out2    <= '0;
            r_out1    <= '0;
            r_out2    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && dir == DIR_LEFT) begin
                l_out1 <= res.first;
                l_out2 <= res.second;
            end
            if (in_valid && dir == DIR_RIGHT) begin
                r_out1 <= res.first;
                r_out2 <= res.second;
            end
        end
    end
endmodule

// File: rtl/bppe_unidir_chk.sv
module bppe_unidir_chk
    import bppe_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic dir_right,
    input llr_t l_in1,
    input llr_t r_in1,
    input logic out_valid,
    input llr_t l_out1,
    input llr_t l_out2,
    input llr_t r_out1,
    input llr_t r_out2
);
    localparam llr_t NEG_FULL = llr_t'(1 << (LLR_W - 1));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(l_out1) && $stable(l_out2) && $stable(r_out1) && $stable(r_out2)));
    // R7
    left_keeps_right_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_right) |=> ($stable(r_out1) && $stable(r_out2)));
    // R7
    right_keeps_left_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir_right) |=> ($stable(l_out1) && $stable(l_out2)));
    // R6
    left_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_right && l_in1 == '0) |=> (l_out1 == '0));
    // R6
    right_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir_right && r_in1 == '0) |=> (r_out1 == '0));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (l_out1 != NEG_FULL && l_out2 != NEG_FULL && r_out1 != NEG_FULL && r_out2 != NEG_FULL));
endmodule

bind bppe_unidir bppe_unidir_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dir_right(dir_right),
    .l_in1(l_in1), .r_in1(r_in1), .out_valid(out_valid),
    .l_out1(l_out1), .l_out2(l_out2), .r_out1(r_out1), .r_out2(r_out2)
);

// File: tb/bppe_unidir_test.sv
module bppe_unidir_test;
    import bppe_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic dir_right = 1'b0;
    llr_t l_in1 = '0, l_in2 = '0, r_in1 = '0, r_in2 = '0;
    logic out_valid;
    llr_t l_out1, l_out2, r_out1, r_out2;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int el1 = 0, el2 = 0, er1 = 0, er2 = 0;

    always #10 clk = ~clk;

    bppe_unidir uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dir_right(dir_right),
        .l_in1(l_in1), .l_in2(l_in2), .r_in1(r_in1), .r_in2(r_in2),
        .out_valid(out_valid), .l_out1(l_out1), .l_out2(l_out2),
        .r_out1(r_out1), .r_out2(r_out2)
    );

    // dir, l1, l2, r1, r2, expected out1, expected out2
    localparam int NV = 10;
    localparam int VEC [NV][7] = '{
        '{0,   3,   4,  -2,   5,   3,   2},
        '{1,   3,   4,  -2,   5,  -2,   3},
        '{0,  -7,  10,   6,   9,  -7,   4},
        '{1,  12, -10, -14,  -9,  14, -15},
        '{0,   0,   5,   7,   3,   0,   5},
        '{1, -16, -16, -16, -16,  15,  -1},
        '{0, -16, -16, -16, -16,  15,  -1},
        '{0,  15,  15,  15,  15,  15,  15},
        '{1,   5,  -5,   0,  -6,   0,  -6},
        '{0,  -1, -15,  -1,  -1,   1, -14}
    };

    function automatic int m_sat(int v);
        if (v > 15) return 15;
        if (v < -15) return -15;
        return v;
    endfunction

    function automatic int m_cs(int a, int b);
        int ma, mb, m;
        if (a == 0 || b == 0) return 0;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        m = (ma < mb) ? ma : mb;
        if (m > 15) m = 15;
        return ((a < 0) != (b < 0)) ? -m : m;
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic apply(int d, int a1, int a2, int b1, int b2);
        @(negedge clk);
        in_valid = 1'b1; dir_right = d[0];
        l_in1 = llr_t'(a1); l_in2 = llr_t'(a2); r_in1 = llr_t'(b1); r_in2 = llr_t'(b2);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare_all(string t1, string t2);
        chk("R8 out_valid", int'(out_valid), 1);
        if (dir_right) begin
            chk(t1, int'(r_out1), er1); chk(t2, int'(r_out2), er2);
            chk("R7 left pair held", int'(l_out1), el1);
            chk("R7 left pair held", int'(l_out2), el2);
        end else begin
            chk(t1, int'(l_out1), el1); chk(t2, int'(l_out2), el2);
            chk("R7 right pair held", int'(r_out1), er1);
            chk("R7 right pair held", int'(r_out2), er2);
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 l_out1", int'(l_out1), 0);
        chk("R10 l_out2", int'(l_out2), 0);
        chk("R10 r_out1", int'(r_out1), 0);
        chk("R10 r_out2", int'(r_out2), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
            if (VEC[i][0] != 0) begin er1 = VEC[i][5]; er2 = VEC[i][6]; end
            else begin el1 = VEC[i][5]; el2 = VEC[i][6]; end
            if (VEC[i][0] != 0) compare_all("R3 r_out1", "R4 r_out2");
            else compare_all("R1 l_out1", "R2 l_out2");
            if (i == 4) chk("R6 zero operand", int'(l_out1), 0);
            if (i == 8) chk("R6 zero operand", int'(r_out1), 0);
            if (i == 3 || i == 5) chk("R5 saturated sum", int'(r_out2), VEC[i][6]);
        end

        // R9: idle with changed inputs
        @(negedge clk);
        dir_right = 1'b0; l_in1 = 5'sd9; l_in2 = 5'sd9; r_in1 = 5'sd9; r_in2 = 5'sd9;
        repeat (3) @(negedge clk);
        chk("R9 out_valid low", int'(out_valid), 0);
        chk("R9 l_out1 held", int'(l_out1), el1);
        chk("R9 l_out2 held", int'(l_out2), el2);
        chk("R9 r_out1 held", int'(r_out1), er1);
        chk("R9 r_out2 held", int'(r_out2), er2);

        // random sweep against the behavioural model
        for (int k = 0; k < 300; k++) begin
            int d, a1, a2, b1, b2, s;
            d = $urandom_range(1, 0);
            a1 = $urandom_range(31, 0) - 16; a2 = $urandom_range(31, 0) - 16;
            b1 = $urandom_range(31, 0) - 16; b2 = $urandom_range(31, 0) - 16;
            apply(d, a1, a2, b1, b2);
            s = m_sat(a2 + b2);
            if (d != 0) begin
                er1 = m_cs(b1, s); er2 = m_sat(m_cs(b1, a1) + b2);
                compare_all("R3 random", "R4 random");
                chk("R5 no -16", int'(r_out1 == -16 || r_out2 == -16), 0);
            end else begin
                el1 = m_cs(a1, s); el2 = m_sat(m_cs(b1, a1) + a2);
                compare_all("R1 random", "R2 random");
                chk("R5 no -16", int'(l_out1 == -16 || l_out2 == -16), 0);
            end
        end

        // R10 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R10 re-reset l_out1", int'(l_out1), 0);
        chk("R10 re-reset r_out2", int'(r_out2), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule